// File: doc/BRIEF.md
# Microcode Next-Address Sequencer

This block is the sequencing half of a microcoded controller. It keeps the current micro-address in a register and, every clock, chooses the next one. There are four ways to do that: step by one, jump through a small opcode dispatch table, return to the fetch routine at address zero, or take a relative micro-branch. A branch is taken when the microinstruction enables it and the condition it names is true. The conditions are ALU overflow and a pending interrupt, so microcode can branch straight into its exception routines.

The control-store word comes in on a port; only its sequencing fields are decoded here. The word's other control fields belong to the datapath and are not part of this block. The word is `cw[10:0]` at the default widths. `cw[10:9]` is the sequence mode, `cw[8:7]` is the condition code, `cw[6]` is the branch enable and `cw[5:0]` is a signed micro-offset. The `upc` output addresses the control store. `br_taken` reports whether the word now being applied will branch.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `upc` becomes 0 at that edge, whatever the other inputs are.
- R2: When sequence mode `cw[10:9]` is 00 and no branch is taken, `upc` becomes `upc + 1` modulo 256, so 0xFF is followed by 0x00.
- R3: When the mode is 01 and no branch is taken, `upc` becomes the dispatch entry for `opcode`: 0x00→0x10, 0x02→0x18, 0x04→0x20, 0x0D→0x28, 0x23→0x30, 0x2B→0x38.
- R4: In mode 01, any opcode that is not in the R3 list sends `upc` to the reserved-opcode routine at 0xF0.
- R5: When the mode is 10 and no branch is taken, `upc` becomes 0.
- R6: When the mode is 11 and no branch is taken, `upc` becomes `upc + 1`.
- R7: The condition code `cw[8:7]` selects the condition: 00 is always true, 01 is `alu_ovf`, 10 is `irq_pend`, and 11 is `alu_ovf | irq_pend`.
- R8: When `cw[6]` is 1 and the selected condition is true, `upc` becomes `upc` plus `cw[5:0]` sign-extended, modulo 256. This applies in every sequence mode.
- R9: When `cw[6]` is 0, `alu_ovf` and `irq_pend` have no effect on `upc` or `br_taken`.
- R10: `br_taken` is high, in the same cycle and without a register, exactly when a branch is taken under R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw | input | 11 | Sequencing fields of the current microinstruction |
| opcode | input | 6 | Opcode of the instruction being decoded |
| alu_ovf | input | 1 | ALU overflow condition |
| irq_pend | input | 1 | Pending interrupt condition |
| upc | output | 8 | Current micro-address |
| br_taken | output | 1 | Branch decision for the current word |

## Verification
Every sequence mode is run with the branch enable off, and each mode's next address is compared against a reference model. All six table opcodes are dispatched, and so are two opcodes outside the table, which separates a table hit from the reserved-opcode fallback. Each condition code is tried with its condition true and with it false, and also with the other condition raised, so a wrong condition mapping shows up. Branches are run with positive and negative offsets, one of them across the 0xFF/0x00 boundary. A taken branch in dispatch mode shows that branching overrides the mode, and conditions raised with the enable off show that they are ignored.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UA_W_DEF  = 8;
    localparam int OP_W_DEF  = 6;
    localparam int OFS_W_DEF = 6;
    localparam int DISP_N    = 6;
    localparam logic [7:0] RSVD_OP_ADDR = 8'hF0;

    typedef enum logic [1:0] {
        SEQ_INC      = 2'b00,
        SEQ_DISPATCH = 2'b01,
        SEQ_FETCH    = 2'b10,
        SEQ_BRANCH   = 2'b11
    } seq_sel_e;

    typedef enum logic [1:0] {
        COND_ALWAYS = 2'b00,
        COND_OVF    = 2'b01,
        COND_IRQ    = 2'b10,
        COND_ANY    = 2'b11
    } cond_sel_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] target;
    } disp_entry_t;

    // Dispatch table contents, one entry per known opcode.
    function automatic disp_entry_t disp_entry(input int idx);
        disp_entry_t e;
        case (idx)
            0:       e = '{opcode: 8'h00, target: 8'h10};
            1:       e = '{opcode: 8'h02, target: 8'h18};
            2:       e = '{opcode: 8'h04, target: 8'h20};
            3:       e = '{opcode: 8'h0D, target: 8'h28};
            4:       e = '{opcode: 8'h23, target: 8'h30};
            5:       e = '{opcode: 8'h2B, target: 8'h38};
            default: e = '{opcode: 8'hFF, target: RSVD_OP_ADDR};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/useq_cond_eval.sv
module useq_cond_eval
    import useq_pkg::*;
(
    input  cond_sel_e cond_sel,
    input  logic      do_branch,
    input  logic      alu_ovf,
    input  logic      irq_pend,
    output logic      taken
);

    logic cond_true;

    always_comb begin
        unique case (cond_sel)
            COND_ALWAYS: cond_true = 1'b1;
            COND_OVF:    cond_true = alu_ovf;
            COND_IRQ:    cond_true = irq_pend;
            COND_ANY:    cond_true = alu_ovf | irq_pend;
            default:     cond_true = 1'b0;
        endcase
    end

    assign taken = do_branch & cond_true;

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OP_W  = OP_W_DEF,
    parameter int UA_W  = UA_W_DEF,
    parameter int N_ENT = DISP_N
) (
    input  logic [OP_W-1:0] opcode,
    output logic [UA_W-1:0] target
);

    logic [N_ENT-1:0] match;
    logic [UA_W-1:0]  ent_tgt [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        localparam disp_entry_t ENT = disp_entry(i);
        assign match[i]   = (opcode == OP_W'(ENT.opcode));
        assign ent_tgt[i] = UA_W'(ENT.target);
    end

    always_comb begin
        target = UA_W'(RSVD_OP_ADDR);
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) target = ent_tgt[i];
        end
    end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int UA_W  = UA_W_DEF,
    parameter int OFS_W = OFS_W_DEF
) (
    input  seq_sel_e         seq_sel,
    input  logic             taken,
    input  logic [UA_W-1:0]  upc,
    input  logic [OFS_W-1:0] offset,
    input  logic [UA_W-1:0]  disp_tgt,
    output logic [UA_W-1:0]  ofs_ext,
    output logic [UA_W-1:0]  next_upc
);

    logic [UA_W-1:0] incr;

    if (UA_W > OFS_W) begin : g_sext
        assign ofs_ext = {{(UA_W-OFS_W){offset[OFS_W-1]}}, offset};
    end else begin : g_trunc
        assign ofs_ext = offset[UA_W-1:0];
    end

    assign incr = upc + UA_W'(1);

    always_comb begin
        if (taken) begin
            next_upc = upc + ofs_ext;
        end else begin
            unique case (seq_sel)
                SEQ_INC:      next_upc = incr;
                SEQ_DISPATCH: next_upc = disp_tgt;
                SEQ_FETCH:    next_upc = '0;
                SEQ_BRANCH:   next_upc = incr;
                default:      next_upc = incr;
            endcase
        end
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int UA_W  = UA_W_DEF,
    parameter int OP_W  = OP_W_DEF,
    parameter int OFS_W = OFS_W_DEF,
    localparam int CW_W = 5 + OFS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW_W-1:0] cw,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_ovf,
    input  logic            irq_pend,
    output logic [UA_W-1:0] upc,
    output logic            br_taken
);

    seq_sel_e         seq_sel;
    cond_sel_e        cond_sel;
    logic             do_branch;
    logic [OFS_W-1:0] offset;
    logic             taken;
    logic [UA_W-1:0]  disp_tgt;
    logic [UA_W-1:0]  ofs_ext;
    logic [UA_W-1:0]  next_upc;
    logic [UA_W-1:0]  upc_q;

    assign seq_sel   = seq_sel_e'(cw[CW_W-1 -: 2]);
    assign cond_sel  = cond_sel_e'(cw[CW_W-3 -: 2]);
    assign do_branch = cw[OFS_W];
    assign offset    = cw[OFS_W-1:0];

    useq_cond_eval i_cond (
        .cond_sel (cond_sel),
        .do_branch(do_branch),
        .alu_ovf  (alu_ovf),
        .irq_pend (irq_pend),
        .taken    (taken)
    );

    useq_dispatch #(.OP_W(OP_W), .UA_W(UA_W), .N_ENT(DISP_N)) i_disp (
        .opcode(opcode),
        .target(disp_tgt)
    );

    useq_next_addr #(.UA_W(UA_W), .OFS_W(OFS_W)) i_next (
        .seq_sel (seq_sel),
        .taken   (taken),
        .upc     (upc_q),
        .offset  (offset),
        .disp_tgt(disp_tgt),
        .ofs_ext (ofs_ext),
        .next_upc(next_upc)
    );

    always_ff @(posedge clk) begin
        if (rst) upc_q <= '0;
        else     upc_q <= next_upc;
    end

    assign upc      = upc_q;
    assign br_taken = taken;

    // R1: reset forces the fetch address
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> upc == '0);

    // R2: sequential step
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (seq_sel == SEQ_INC && !br_taken) |=> upc == UA_W'($past(upc) + UA_W'(1)));

    // R5: return to fetch
    assert_fetch_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_sel == SEQ_FETCH && !br_taken) |=> upc == '0);

    // R6: untaken conditional branch falls through
    assert_fallthru_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_sel == SEQ_BRANCH && !br_taken) |=> upc == UA_W'($past(upc) + UA_W'(1)));

    // R7: overflow code follows the overflow input when enabled
    assert_cond_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (do_branch && cond_sel == COND_OVF) |-> br_taken == alu_ovf);

    // R8: taken branch lands at the relative target
    assert_branch_R8: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> upc == UA_W'($past(upc) + $past(ofs_ext)));

    // R9: disabled branch ignores conditions
    assert_nobranch_R9: assert property (@(posedge clk) disable iff (rst)
        !do_branch |-> !br_taken);

endmodule

// File: tb/test_useq_sequencer.sv
`timescale 1ns/1ps
module test_useq_sequencer;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] cw = '0;
    logic [5:0]  opcode = '0;
    logic        alu_ovf = 1'b0;
    logic        irq_pend = 1'b0;
    logic [7:0]  upc;
    logic        br_taken;

    int    checks = 0;
    int    errors = 0;
    item_t sb_q[$];
    logic [7:0] m_upc = 8'h00;

    always #10 clk = ~clk;

    useq_sequencer i_useq_sequencer (
        .clk(clk), .rst(rst), .cw(cw), .opcode(opcode),
        .alu_ovf(alu_ovf), .irq_pend(irq_pend),
        .upc(upc), .br_taken(br_taken)
    );

    function automatic logic [7:0] tbl(input logic [5:0] op);
        case (op)
            6'h00:   return 8'h10;
            6'h02:   return 8'h18;
            6'h04:   return 8'h20;
            6'h0D:   return 8'h28;
            6'h23:   return 8'h30;
            6'h2B:   return 8'h38;
            default: return 8'hF0;
        endcase
    endfunction

    function automatic logic cond_of(input logic [1:0] c, input logic o, input logic i);
        case (c)
            2'b00:   return 1'b1;
            2'b01:   return o;
            2'b10:   return i;
            default: return o | i;
        endcase
    endfunction

    task automatic drive(input logic r, input logic [1:0] s, input logic [1:0] c,
                         input logic dob, input logic [5:0] off, input logic [5:0] op,
                         input logic o, input logic i, input string tag);
        logic tk;
        item_t it;
        @(negedge clk);
        rst = r; cw = {s, c, dob, off}; opcode = op; alu_ovf = o; irq_pend = i;
        #1;
        tk = dob & cond_of(c, o, i);
        if (!r) begin
            checks++;
            if (br_taken !== tk) begin
                errors++;
                $display("FAIL R10 %s br_taken actual %b expected %b", tag, br_taken, tk);
            end
        end
        if (r)                m_upc = 8'h00;
        else if (tk)          m_upc = m_upc + {{2{off[5]}}, off};
        else if (s == 2'b01)  m_upc = tbl(op);
        else if (s == 2'b10)  m_upc = 8'h00;
        else                  m_upc = m_upc + 8'h01;
        it.exp = m_upc;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (upc !== it.exp) begin
                    errors++;
                    $display("FAIL %s upc actual %h expected %h", it.tag, upc, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [5:0] OPS [6] = '{6'h00, 6'h02, 6'h04, 6'h0D, 6'h23, 6'h2B};

    initial begin : main
        // R1: reset wins over a branching word
        drive(1, 2'b11, 2'b00, 1, 6'd5, 6'h00, 1, 1, "R1 reset");
        drive(1, 2'b01, 2'b00, 1, 6'd9, 6'h04, 0, 0, "R1 reset");
        // R2: step
        drive(0, 2'b00, 2'b01, 0, 6'd0, 6'h00, 0, 0, "R2 step");
        drive(0, 2'b00, 2'b00, 0, 6'd7, 6'h00, 0, 0, "R2 step");
        drive(0, 2'b00, 2'b10, 0, 6'd0, 6'h00, 0, 0, "R2 step");
        // R5: fetch
        drive(0, 2'b10, 2'b00, 0, 6'd3, 6'h00, 0, 0, "R5 fetch");
        // R3: every table entry
        for (int k = 0; k < 6; k++) begin
            drive(0, 2'b01, 2'b00, 0, 6'd0, OPS[k], 0, 0, "R3 dispatch");
            drive(0, 2'b10, 2'b00, 0, 6'd0, 6'h00, 0, 0, "R5 fetch");
        end
        // R4: opcodes outside the table
        drive(0, 2'b01, 2'b00, 0, 6'd0, 6'h3F, 0, 0, "R4 reserved");
        drive(0, 2'b01, 2'b00, 0, 6'd0, 6'h01, 0, 0, "R4 reserved");
        // R6: untaken conditional mode
        drive(0, 2'b11, 2'b00, 0, 6'd4, 6'h00, 0, 0, "R6 fallthru");
        drive(0, 2'b11, 2'b01, 1, 6'd4, 6'h00, 0, 1, "R6 R7 ovf false");
        // R7/R8: conditions
        drive(0, 2'b00, 2'b01, 1, 6'd4, 6'h00, 1, 0, "R7 R8 ovf true");
        drive(0, 2'b00, 2'b10, 1, 6'h3E, 6'h00, 0, 0, "R7 irq false");
        drive(0, 2'b00, 2'b10, 1, 6'h3E, 6'h00, 1, 1, "R7 R8 irq true neg");
        drive(0, 2'b00, 2'b11, 1, 6'd3, 6'h00, 0, 1, "R7 any irq");
        drive(0, 2'b00, 2'b11, 1, 6'd1, 6'h00, 1, 0, "R7 any ovf");
        drive(0, 2'b00, 2'b11, 1, 6'd9, 6'h00, 0, 0, "R7 any none");
        drive(0, 2'b00, 2'b00, 1, 6'h3F, 6'h00, 0, 0, "R7 R8 always");
        // R9: conditions ignored without enable
        drive(0, 2'b01, 2'b00, 0, 6'd7, 6'h04, 1, 1, "R9 ignored");
        drive(0, 2'b11, 2'b11, 0, 6'd7, 6'h00, 1, 1, "R9 ignored");
        // R8: taken branch overrides dispatch
        drive(0, 2'b01, 2'b00, 1, 6'd1, 6'h2B, 0, 0, "R8 override");
        drive(0, 2'b10, 2'b01, 1, 6'd2, 6'h00, 1, 0, "R8 override fetch");
        // R8 / R2: wrap at the ends
        drive(0, 2'b10, 2'b00, 0, 6'd0, 6'h00, 0, 0, "R5 fetch");
        drive(0, 2'b00, 2'b00, 1, 6'h3F, 6'h00, 0, 0, "R8 wrap down");
        drive(0, 2'b00, 2'b00, 0, 6'd0, 6'h00, 0, 0, "R2 wrap");
        drive(0, 2'b00, 2'b00, 1, 6'h20, 6'h00, 0, 0, "R8 most negative");
        // R1: reset mid-run
        drive(1, 2'b01, 2'b00, 0, 6'd0, 6'h04, 0, 0, "R1 mid reset");
        drive(0, 2'b00, 2'b00, 0, 6'd0, 6'h00, 0, 0, "R2 after reset");
        @(posedge clk);
        #5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule